// File: doc/BRIEF.md
# Write-Only Serial Program Port for a Frequency Synthesizer

This block is the programming front end of a frequency synthesizer. It listens on a two-wire I2C bus as a slave that accepts writes only. It detects START and STOP conditions and compares the 7-bit device address with a 2-bit strap input. It acknowledges every byte it accepts. It then places incoming data bytes into three registers: a 15-bit divider word, a control register and a port register. The clock and data lines reach the block already synchronized to the system clock.

The most significant bit of each data byte sets its meaning. A leading 0 opens a divider pair: that byte holds the top seven divider bits in a staging register, and the byte after it holds the low eight bits. The 15-bit word is committed only when both bytes have arrived. A leading 1 opens a control/port pair: that byte is the control byte, and the byte after it sets the port bits. After each pair the next byte is classified again. A single transfer can therefore write both pairs in either order, write only one pair, or repeat pairs until a STOP.

Top module: `synth_prog_if`

## Requirements
- R1: The block acknowledges an address byte only when its upper five bits are 11000, bits 2:1 equal `addrSel` (bit 2 matching `addrSel[1]`), and bit 0 (the direction bit) is 0.
- R2: A data byte with MSB 0 stages bits 6:0 as divider bits 14:8. The following byte supplies divider bits 7:0. `divWord` then equals {staged bits, second byte}.
- R3: A control byte (MSB 1) maps bit 6 to `pumpHigh`, bits 5:3 to `testBits[2:0]`, bits 2:1 to `refSel[1:0]` and bit 0 to `tuneOff`. The byte after a control byte is copied whole to `portBits`.
- R4: `divWord` changes only at the end of the second byte of a divider pair. A lone first divider byte leaves it unchanged.
- R5: The control register loads only at the end of a control byte, and the port register only at the end of a port byte. Each leaves the other registers untouched.
- R6: After one address byte, any number of data bytes is accepted and acknowledged until a STOP. A later pair of the same kind overwrites the earlier one.
- R7: After the second byte of any pair, the next byte is classified again by its MSB. The orders divider-then-control and control-then-divider both work, and so does a transfer holding only one pair.
- R8: For an accepted address byte and for every data byte, `sdaPullLow` is high during the ninth SCL pulse. It rises only while SCL is low and is low again before the next byte's first bit.
- R9: A mismatched address or a read request gets no acknowledge. The block then ignores all bytes until the next START.
- R10: A START or STOP between the two bytes of a pair abandons that pair. The first byte of the next transfer is classified afresh, and the committed registers keep their values.
- R11: After reset `divWord` is 0, `pumpHigh` 0, `testBits` 001, `refSel` 00, `tuneOff` 0, `portBits` 0 and `sdaPullLow` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line (wired-AND level) |
| addrSel | input | 2 | Strap value the two programmable address bits must match |
| sdaPullLow | output | 1 | High to pull the data line low for an acknowledge |
| divWord | output | 15 | Committed divider ratio |
| pumpHigh | output | 1 | Charge-pump current select |
| testBits | output | 3 | Test-mode bits |
| refSel | output | 2 | Reference divider ratio select |
| tuneOff | output | 1 | High disables the tuning output |
| portBits | output | 8 | Band-switch and general port outputs |

## Verification
A wrong pair-tracking state in this block shows up one byte later as a byte in the wrong register. For example, a control byte landing in the divider low half changes `divWord` at the next ninth-clock check. A stale staging state after START or STOP shows up the same way in the first data byte of the next transfer. A wrong address or phase decision shows up at once as a missing or unexpected `sdaPullLow` in the ninth clock of that byte. The bench therefore samples the acknowledge of every byte and reads every output register after each transfer.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = BYTE_W - 1;
  localparam int DIV_W  = HI_W + BYTE_W;
  localparam int CNT_W  = 4;
  localparam logic [4:0]      DEV_ID    = 5'b11000;
  localparam logic [HI_W-1:0] CTL_RESET = 7'b0_001_00_0;

  typedef struct packed {
    logic              loadDb1;
    logic              loadDb2;
    logic              loadCtl;
    logic              loadPort;
    logic [BYTE_W-1:0] dataByte;
  } strobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;
  typedef enum logic [1:0] {EXP_LEAD, EXP_DIVLO, EXP_PORT} expect_e;
endpackage

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrSel,
  output logic       ackDrive,
  output strobe_t    stb
);
  logic              sclQ, sdaQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              ackPend;
  phase_e            phase;
  expect_e           nextKind;

  logic sclRise, sclFall, startDet, stopDet, addrHit;
  logic [BYTE_W-1:0] byteNext;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign byteNext = {shiftReg[BYTE_W-2:0], sdaIn};
  assign addrHit  = (byteNext[7:3] == DEV_ID) && (byteNext[2:1] == addrSel) && !byteNext[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackPend  <= 1'b0;
      ackDrive <= 1'b0;
      phase    <= PH_IDLE;
      nextKind <= EXP_LEAD;
      stb      <= '0;
    end else begin
      sclQ         <= sclIn;
      sdaQ         <= sdaIn;
      stb.loadDb1  <= 1'b0;
      stb.loadDb2  <= 1'b0;
      stb.loadCtl  <= 1'b0;
      stb.loadPort <= 1'b0;
      if (startDet || stopDet) begin
        phase    <= startDet ? PH_ADDR : PH_IDLE;
        bitCnt   <= '0;
        ackPend  <= 1'b0;
        ackDrive <= 1'b0;
        nextKind <= EXP_LEAD;
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          if (bitCnt < CNT_W'(BYTE_W)) begin
            shiftReg <= byteNext;
            bitCnt   <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(BYTE_W - 1)) begin
              if (phase == PH_ADDR) begin
                ackPend <= addrHit;
                phase   <= addrHit ? PH_DATA : PH_IDLE;
              end else begin
                ackPend      <= 1'b1;
                stb.dataByte <= byteNext;
                unique case (nextKind)
                  EXP_DIVLO: begin stb.loadDb2  <= 1'b1; nextKind <= EXP_LEAD; end
                  EXP_PORT:  begin stb.loadPort <= 1'b1; nextKind <= EXP_LEAD; end
                  default: begin
                    if (byteNext[BYTE_W-1]) begin
                      stb.loadCtl <= 1'b1;
                      nextKind    <= EXP_PORT;
                    end else begin
                      stb.loadDb1 <= 1'b1;
                      nextKind    <= EXP_DIVLO;
                    end
                  end
                endcase
              end
            end
          end else begin
            bitCnt <= CNT_W'(BYTE_W + 1);
          end
        end else if (sclFall) begin
          if (bitCnt == CNT_W'(BYTE_W)) begin
            ackDrive <= ackPend;
          end else if (bitCnt == CNT_W'(BYTE_W + 1)) begin
            ackDrive <= 1'b0;
            ackPend  <= 1'b0;
            bitCnt   <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [DIV_W-1:0] divWord,
  output logic [HI_W-1:0]  ctlReg,
  output logic [BYTE_W-1:0] portReg
);
  logic [HI_W-1:0] stageHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageHi <= '0;
      divWord <= '0;
      ctlReg  <= CTL_RESET;
      portReg <= '0;
    end else begin
      if (stb.loadDb1)  stageHi <= stb.dataByte[HI_W-1:0];
      if (stb.loadDb2)  divWord <= {stageHi, stb.dataByte};
      if (stb.loadCtl)  ctlReg  <= stb.dataByte[HI_W-1:0];
      if (stb.loadPort) portReg <= stb.dataByte;
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  addrSel,
  output logic        sdaPullLow,
  output logic [14:0] divWord,
  output logic        pumpHigh,
  output logic [2:0]  testBits,
  output logic [1:0]  refSel,
  output logic        tuneOff,
  output logic [7:0]  portBits
);
  strobe_t          stb;
  logic [HI_W-1:0]  ctlReg;

  synth_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .ackDrive(sdaPullLow), .stb(stb)
  );

  synth_prog_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .divWord(divWord), .ctlReg(ctlReg), .portReg(portBits)
  );

  assign pumpHigh = ctlReg[6];
  assign testBits = ctlReg[5:3];
  assign refSel   = ctlReg[2:1];
  assign tuneOff  = ctlReg[0];
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaPullLow,
  input logic [14:0] divWord,
  input logic        pumpHigh,
  input logic [2:0]  testBits,
  input logic [1:0]  refSel,
  input logic        tuneOff,
  input logic [7:0]  portBits,
  input strobe_t     stb
);
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadDb2 |=> $stable(divWord)); // R4
  AST_DIV_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDb2 |=> divWord[7:0] == $past(stb.dataByte)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCtl |=> $stable({pumpHigh, testBits, refSel, tuneOff})); // R5
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadPort |=> $stable(portBits)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadDb1, stb.loadDb2, stb.loadCtl, stb.loadPort})); // R7
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn); // R8
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .divWord(divWord), .pumpHigh(pumpHigh), .testBits(testBits),
  .refSel(refSel), .tuneOff(tuneOff), .portBits(portBits), .stb(stb)
);

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'b10;
  logic sdaPullLow;
  logic [14:0] divWord;
  logic pumpHigh, tuneOff;
  logic [2:0] testBits;
  logic [1:0] refSel;
  logic [7:0] portBits;
  logic sdaBus;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_if u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .divWord(divWord), .pumpHigh(pumpHigh),
    .testBits(testBits), .refSel(refSel), .tuneOff(tuneOff), .portBits(portBits)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaDrv = 1'b1; waitN(HALF);
    sclDrv = 1'b1; waitN(HALF);
    sdaDrv = 1'b0; waitN(HALF);
    sclDrv = 1'b0; waitN(HALF);
  endtask

  task automatic busStop;
    sdaDrv = 1'b0; waitN(HALF);
    sclDrv = 1'b1; waitN(HALF);
    sdaDrv = 1'b1; waitN(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitN(HALF);
      sclDrv = 1'b1; waitN(HALF);
      sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; waitN(HALF);
    sclDrv = 1'b1; waitN(2);
    acked = !sdaBus;
    waitN(HALF - 2);
    sclDrv = 1'b0; waitN(HALF);
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] ma, input bit rd);
    return {5'b11000, ma, rd};
  endfunction

  task automatic sendAcked(input string tag, input logic [7:0] b);
    bit a;
    sendByte(b, a);
    chk({tag, " R8 ack"}, a, 1);
    chk({tag, " R8 released"}, sdaPullLow, 0);
  endtask

  task automatic checkRegs(input string tag, input int dv, input int ctl, input int prt);
    chk({tag, " divWord"}, divWord, dv);
    chk({tag, " control"}, {pumpHigh, testBits, refSel, tuneOff}, ctl);
    chk({tag, " portBits"}, portBits, prt);
  endtask

  task automatic testReset;
    checkRegs("R11 reset", 0, 7'b0001000, 0);
    chk("R11 reset sdaPullLow", sdaPullLow, 0);
  endtask

  task automatic testFullWrite;
    busStart();
    sendAcked("R1 address", addrByte(2'b10, 1'b0));
    sendAcked("R2 db1", 8'h35);
    chk("R4 after db1 only", divWord, 0);
    sendAcked("R2 db2", 8'hA7);
    chk("R2 divider", divWord, 15'h35A7);
    sendAcked("R3 ctl", 8'hD5);
    chk("R3 pumpHigh", pumpHigh, 1);
    chk("R3 testBits", testBits, 3'b010);
    chk("R3 refSel", refSel, 2'b10);
    chk("R3 tuneOff", tuneOff, 1);
    chk("R5 ports untouched by ctl", portBits, 0);
    sendAcked("R3 port", 8'h5A);
    busStop();
    checkRegs("R6 full", 15'h35A7, 7'h55, 8'h5A);
  endtask

  task automatic testSwappedOrder;
    busStart();
    sendAcked("R7 address", addrByte(2'b10, 1'b0));
    sendAcked("R7 ctl first", 8'h88);
    chk("R5 div untouched by ctl", divWord, 15'h35A7);
    sendAcked("R7 port", 8'h81);
    sendAcked("R7 db1", 8'h7F);
    sendAcked("R7 db2", 8'h01);
    busStop();
    checkRegs("R7 swapped", 15'h7F01, 7'h08, 8'h81);
  endtask

  task automatic testPartial;
    busStart();
    sendAcked("R4 address", addrByte(2'b10, 1'b0));
    sendAcked("R4 lone db1", 8'h22);
    busStop();
    checkRegs("R4 lone db1", 15'h7F01, 7'h08, 8'h81);
    busStart();
    sendAcked("R7 address", addrByte(2'b10, 1'b0));
    sendAcked("R7 db1", 8'h22);
    sendAcked("R7 db2", 8'h33);
    busStop();
    checkRegs("R7 partial divider", 15'h2233, 7'h08, 8'h81);
  endtask

  task automatic testDiscard;
    busStart();
    sendAcked("R10 address", addrByte(2'b10, 1'b0));
    sendAcked("R10 db1", 8'h11);
    busStop();
    busStart();
    sendAcked("R10 address", addrByte(2'b10, 1'b0));
    sendAcked("R10 ctl after stop", 8'hBE);
    busStop();
    checkRegs("R10 stop mid pair", 15'h2233, 7'h3E, 8'h81);
    busStart();
    sendAcked("R10 address", addrByte(2'b10, 1'b0));
    sendAcked("R10 db1", 8'h44);
    busStart();
    sendAcked("R10 re-address", addrByte(2'b10, 1'b0));
    sendAcked("R10 ctl after restart", 8'hC1);
    sendAcked("R10 port", 8'h0F);
    busStop();
    checkRegs("R10 restart mid pair", 15'h2233, 7'h41, 8'h0F);
  endtask

  task automatic testMismatch;
    bit a;
    busStart();
    sendByte(addrByte(2'b01, 1'b0), a);
    chk("R9 wrong address no ack", a, 0);
    sendByte(8'h12, a);
    chk("R9 ignored byte no ack", a, 0);
    sendByte(8'h34, a);
    busStop();
    busStart();
    sendByte(addrByte(2'b10, 1'b1), a);
    chk("R9 read request no ack", a, 0);
    sendByte(8'hFF, a);
    sendByte(8'h00, a);
    busStop();
    checkRegs("R9 ignored", 15'h2233, 7'h41, 8'h0F);
    addrSel = 2'b01;
    busStart();
    sendAcked("R1 strap 01", addrByte(2'b01, 1'b0));
    sendAcked("R1 port pair ctl", 8'h88);
    sendAcked("R1 port pair port", 8'h3C);
    busStop();
    checkRegs("R1 strap 01", 15'h2233, 7'h08, 8'h3C);
    addrSel = 2'b10;
  endtask

  task automatic testAutoIncrement;
    busStart();
    sendAcked("R6 address", addrByte(2'b10, 1'b0));
    sendAcked("R6 db1 a", 8'h01);
    sendAcked("R6 db2 a", 8'h02);
    chk("R6 first pair", divWord, 15'h0102);
    sendAcked("R6 db1 b", 8'h03);
    chk("R4 held mid pair", divWord, 15'h0102);
    sendAcked("R6 db2 b", 8'h04);
    sendAcked("R6 ctl", 8'hF7);
    sendAcked("R6 port", 8'hE1);
    busStop();
    checkRegs("R6 auto increment", 15'h0304, 7'h77, 8'hE1);
  endtask

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    testReset();
    testFullWrite();
    testSwappedOrder();
    testPartial();
    testDiscard();
    testMismatch();
    testAutoIncrement();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule